// File: doc/BRIEF.md
# Multi-Cycle Register-Memory Processor Core

This block is a small processor core that runs one instruction at a time over several clock cycles. It has one memory port: a 10-bit word address, a 16-bit write-data path, a 16-bit read-data path and a single direction line (0 = read, 1 = write). Memory sits outside the core and answers reads combinationally in the same cycle as the address. Each instruction is a 16-bit word with three fields. Bits 15:12 hold the opcode. Bits 11:10 select one of four 16-bit general registers. Bits 9:0 hold a memory address or a jump target.

A control state machine walks through fetch, decode, a memory cycle and an arithmetic cycle, and then writes the result back. The program counter, the instruction register, two operand registers and a result register sit between those steps. Arithmetic uses two's complement and wraps modulo 2^16. Eight opcodes are defined. The other eight stop the core and flag an error. After reset the core begins fetching at an address taken from an input pin.

Top module: `mc_core`

## Requirements
- R1: Instruction fields are decoded as opcode = bits 15:12, register number = bits 11:10 and address = bits 9:0. The opcode values are: 0 stop, 1 load, 2 store, 3 add, 4 subtract, 5 jump, 6 jump-if-zero and 7 jump-if-negative.
- R2: While reset is low and in the first cycle after it, `halted` and `err_illegal` are 0, `mem_we` is 0, and `mem_addr` equals `boot_addr`. Execution therefore starts at `boot_addr`.
- R3: Every fetch drives the program counter onto `mem_addr` with `mem_we` = 0, latches `mem_rdata` as the instruction, and advances the program counter by 1.
- R4: Load copies memory[addr] into the selected register. Store writes the selected register to memory[addr] with `mem_we` = 1 for exactly one cycle.
- R5: Add and subtract combine the selected register with memory[addr] modulo 2^16 and write the result back into that register.
- R6: Jump loads the address field into the program counter, so the next fetch reads that address.
- R7: Jump-if-zero is taken when the register equals 0. Jump-if-negative is taken when bit 15 of the register is 1. When a branch is not taken, execution continues at the next sequential word.
- R8: Opcode 0 raises `halted`, which then stays 1 until reset. While halted, `mem_we` stays 0.
- R9: Opcodes 8 to 15 raise both `halted` and `err_illegal`, and the instruction is not executed. Both flags stay set until reset.
- R10: Cycle counts per instruction: load and store take 3 cycles, add and subtract take 5, jumps take 2, and stop raises `halted` 2 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_addr | input | 10 | Address of the first instruction, loaded into the program counter at reset |
| mem_addr | output | 10 | Memory word address |
| mem_we | output | 1 | Memory direction: 0 read, 1 write |
| mem_wdata | output | 16 | Data written to memory |
| mem_rdata | input | 16 | Data returned by memory in the same cycle |
| halted | output | 1 | Core has stopped |
| err_illegal | output | 1 | Stop was caused by an undefined opcode |

## Verification
The registers cannot be seen from outside, so the bench exposes each one by storing it to memory, and it follows control flow by checking which marker locations receive writes. A wrong register value or a wrong ALU result appears in the next store, a few cycles later. A wrong branch decision shows up as a write to the wrong marker location, or as a different halt cycle count. A fault in the program counter or in the state sequencing changes the exact cycle on which `halted` rises, and the bench checks that cycle against a value it computes from the per-instruction cycle counts.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int MC_DW  = 16;
  localparam int MC_AW  = 10;
  localparam int MC_OPW = 4;
  localparam int MC_RW  = 2;

  typedef enum logic [MC_OPW-1:0] {
    OP_STOP  = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_JMP   = 4'd5,
    OP_JZ    = 4'd6,
    OP_JN    = 4'd7
  } op_e;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_MEM, S_ALU, S_WB, S_HALT
  } st_e;

  function automatic logic [MC_DW-1:0] alu_calc(input logic [MC_DW-1:0] a,
                                                input logic [MC_DW-1:0] b,
                                                input logic sub);
    return sub ? (a - b) : (a + b);
  endfunction

  function automatic logic branch_taken(input logic [MC_OPW-1:0] op,
                                        input logic [MC_DW-1:0] v);
    case (op)
      OP_JMP:  return 1'b1;
      OP_JZ:   return (v == '0);
      OP_JN:   return v[MC_DW-1];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW = 16,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int NREG = 1 << RW;
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= '0;
      else if (we && sel == RW'(g)) regs[g] <= wdata;
    end
  end

  assign rdata = regs[sel];
endmodule

// File: rtl/mc_alu.sv
module mc_alu #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic          ld_out,
  input  logic          sub,
  input  logic [DW-1:0] din_a,
  input  logic [DW-1:0] din_b,
  output logic [DW-1:0] res
);
  import mc_pkg::*;
  logic [DW-1:0] in1_q, in2_q, out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in1_q <= '0;
      in2_q <= '0;
      out_q <= '0;
    end else begin
      if (ld_a)   in1_q <= din_a;
      if (ld_b)   in2_q <= din_b;
      if (ld_out) out_q <= alu_calc(in1_q, in2_q, sub);
    end
  end

  assign res = out_q;

  // R5: the operand registers stay fixed while the result is being computed
  p_operands_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_out |=> $stable(in1_q) && $stable(in2_q));
endmodule

// File: rtl/mc_core.sv
module mc_core #(
  parameter int DW  = mc_pkg::MC_DW,
  parameter int AW  = mc_pkg::MC_AW,
  parameter int OPW = mc_pkg::MC_OPW,
  parameter int RW  = mc_pkg::MC_RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] boot_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic          err_illegal
);
  import mc_pkg::*;
  localparam int OP_LSB  = DW - OPW;
  localparam int REG_LSB = OP_LSB - RW;

  st_e           state_q, state_d;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] ir_q;
  logic          illegal_q;

  logic [OPW-1:0] op;
  logic [RW-1:0]  rsel;
  logic [AW-1:0]  afield;
  assign op     = ir_q[DW-1 -: OPW];
  assign rsel   = ir_q[OP_LSB-1 -: RW];
  assign afield = ir_q[AW-1:0];

  logic          rf_we, rf_from_mem;
  logic [DW-1:0] rf_rdata, rf_wdata, alu_res;
  logic          alu_ld_a, alu_ld_b, alu_ld_out, is_sub;
  logic          pc_jump, set_illegal;

  // named events for the checks
  logic fetch_ev, store_ev, halt_ev;
  assign fetch_ev = (state_q == S_FETCH);
  assign store_ev = (state_q == S_MEM) && (op == OP_STORE);
  assign halt_ev  = (state_q == S_HALT);

  assign is_sub = (op == OP_SUB);

  always_comb begin
    state_d     = state_q;
    rf_we       = 1'b0;
    rf_from_mem = 1'b0;
    alu_ld_a    = 1'b0;
    alu_ld_b    = 1'b0;
    alu_ld_out  = 1'b0;
    pc_jump     = 1'b0;
    set_illegal = 1'b0;
    mem_addr    = pc_q;
    mem_we      = 1'b0;
    case (state_q)
      S_FETCH: state_d = S_DECODE;
      S_DECODE: begin
        case (op)
          OP_STOP:           state_d = S_HALT;
          OP_LOAD, OP_STORE: state_d = S_MEM;
          OP_ADD, OP_SUB: begin
            alu_ld_a = 1'b1;
            state_d  = S_MEM;
          end
          OP_JMP, OP_JZ, OP_JN: begin
            pc_jump = branch_taken(op, rf_rdata);
            state_d = S_FETCH;
          end
          default: begin
            set_illegal = 1'b1;
            state_d     = S_HALT;
          end
        endcase
      end
      S_MEM: begin
        mem_addr = afield;
        if (op == OP_STORE) begin
          mem_we  = 1'b1;
          state_d = S_FETCH;
        end else if (op == OP_LOAD) begin
          rf_we       = 1'b1;
          rf_from_mem = 1'b1;
          state_d     = S_FETCH;
        end else begin
          alu_ld_b = 1'b1;
          state_d  = S_ALU;
        end
      end
      S_ALU: begin
        alu_ld_out = 1'b1;
        state_d    = S_WB;
      end
      S_WB: begin
        rf_we   = 1'b1;
        state_d = S_FETCH;
      end
      default: state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_FETCH;
      pc_q      <= boot_addr;
      ir_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fetch_ev) begin
        ir_q <= mem_rdata;
        pc_q <= pc_q + AW'(1);
      end else if (pc_jump) begin
        pc_q <= afield;
      end
      if (set_illegal) illegal_q <= 1'b1;
    end
  end

  assign rf_wdata    = rf_from_mem ? mem_rdata : alu_res;
  assign mem_wdata   = rf_rdata;
  assign halted      = halt_ev;
  assign err_illegal = illegal_q;

  mc_regfile #(.DW(DW), .RW(RW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .sel(rsel),
    .wdata(rf_wdata), .rdata(rf_rdata)
  );

  mc_alu #(.DW(DW)) u_alu (
    .clk(clk), .rst_n(rst_n), .ld_a(alu_ld_a), .ld_b(alu_ld_b),
    .ld_out(alu_ld_out), .sub(is_sub), .din_a(rf_rdata),
    .din_b(mem_rdata), .res(alu_res)
  );

  p_fetch_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |-> !mem_we && mem_addr == pc_q);
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |=> pc_q == $past(pc_q) + AW'(1));
  p_store_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we && !rf_we);
  p_illegal_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |-> halted);
  p_illegal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |=> err_illegal);
  p_alu_then_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alu_ld_out |=> rf_we && !rf_from_mem);
endmodule

// File: tb/mc_core_tb.sv
module mc_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  boot_addr = '0;
  logic [9:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        halted, err_illegal;

  logic [15:0] mem [1024];
  int total = 0, bad = 0;
  int cyc_all = 0;
  int halt_wr = 0;

  always #2 clk = ~clk;

  mc_core u_dut (
    .clk(clk), .rst_n(rst_n), .boot_addr(boot_addr), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .err_illegal(err_illegal)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (rst_n && halted && mem_we) halt_wr++;
    cyc_all++;
    if (cyc_all > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc_all);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] enc(input int op, input int rn, input int a);
    return {4'(op), 2'(rn), 10'(a)};
  endfunction

  function automatic logic [15:0] ref_alu(input logic [15:0] a, input logic [15:0] b,
                                          input bit sub);
    int s;
    s = sub ? (int'(a) - int'(b)) : (int'(a) + int'(b));
    return 16'(s & 32'hFFFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset(input logic [9:0] sa);
    rst_n = 1'b0;
    boot_addr = sa;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 halted in reset", halted, 0);
    rst_n = 1'b1;
    check("R2 boot address", mem_addr, sa);
    check("R2 we at start", mem_we, 0);
    check("R2 illegal at start", err_illegal, 0);
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  int cyc;

  initial begin
    // Directed: load / add / store (R4, R5, R10)
    clear_mem();
    mem[10'h080] = 16'h1A01; mem[10'h081] = 16'h3A02;
    mem[10'h082] = 16'h2A00; mem[10'h083] = 16'h0000;
    mem[10'h201] = 16'd9;    mem[10'h202] = 16'd6;
    do_reset(10'h080);
    run(cyc);
    check("R5 add result stored", mem[10'h200], 16'h000F);
    check("R10 cycles 3+5+3+2", cyc, 13);
    check("R8 halted", halted, 1);
    check("R9 no illegal on stop", err_illegal, 0);
    halt_wr = 0;
    repeat (20) @(negedge clk);
    check("R8 halted sticky", halted, 1);
    check("R8 no write while halted", halt_wr, 0);

    // Directed: branches and jump (R6, R7, R10)
    clear_mem();
    mem[10'h010] = enc(1, 1, 10'h320);
    mem[10'h011] = enc(6, 1, 10'h015);
    mem[10'h012] = enc(7, 1, 10'h016);
    mem[10'h013] = enc(2, 1, 10'h321);
    mem[10'h014] = enc(0, 0, 0);
    mem[10'h015] = enc(0, 0, 0);
    mem[10'h016] = enc(5, 0, 10'h019);
    mem[10'h017] = enc(2, 1, 10'h322);
    mem[10'h018] = enc(0, 0, 0);
    mem[10'h019] = enc(1, 3, 10'h323);
    mem[10'h01A] = enc(7, 3, 10'h014);
    mem[10'h01B] = enc(6, 3, 10'h01D);
    mem[10'h01C] = enc(2, 1, 10'h324);
    mem[10'h01D] = enc(2, 1, 10'h325);
    mem[10'h01E] = enc(0, 0, 0);
    mem[10'h320] = 16'h8000; mem[10'h323] = 16'h0000;
    mem[10'h321] = 16'h5555; mem[10'h322] = 16'h5555;
    mem[10'h324] = 16'h5555; mem[10'h325] = 16'h5555;
    do_reset(10'h010);
    run(cyc);
    check("R7 not-taken zero test skipped", mem[10'h321], 16'h5555);
    check("R6 jump skipped word", mem[10'h322], 16'h5555);
    check("R7 taken zero test", mem[10'h324], 16'h5555);
    check("R7 bit15 negative path", mem[10'h325], 16'h8000);
    check("R10 branch cycle total", cyc, 21);

    // Directed: illegal opcode (R9)
    clear_mem();
    mem[10'h040] = enc(1, 0, 10'h330);
    mem[10'h041] = enc(11, 0, 10'h331);
    mem[10'h042] = enc(2, 0, 10'h331);
    mem[10'h330] = 16'h1234;
    do_reset(10'h040);
    run(cyc);
    check("R9 illegal flag", err_illegal, 1);
    check("R9 halted", halted, 1);
    check("R9 not executed", mem[10'h331], 16'h0000);
    check("R9 halt cycle", cyc, 5);

    // Random: arithmetic, register selection, branch routing (R1 R3 R5 R7)
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED);
    end
    for (int t = 0; t < 40; t++) begin
      logic [15:0] a, b, r, ins_last;
      logic [9:0] s;
      int rn, sub, path;
      clear_mem();
      a = 16'($urandom); b = 16'($urandom);
      if (t % 5 == 0) b = a;
      sub = (t % 5 == 0) ? 1 : int'($urandom % 2);
      rn = int'($urandom % 4);
      s = 10'($urandom % 16'h0F0);
      mem[s]    = enc(1, rn, 10'h300);
      mem[s+1]  = enc(sub ? 4 : 3, rn, 10'h301);
      mem[s+2]  = enc(2, rn, 10'h302);
      mem[s+3]  = enc(6, rn, s + 7);
      mem[s+4]  = enc(7, rn, s + 9);
      mem[s+5]  = enc(2, rn, 10'h303);
      mem[s+6]  = enc(0, 0, 0);
      mem[s+7]  = enc(2, rn, 10'h304);
      mem[s+8]  = enc(0, 0, 0);
      mem[s+9]  = enc(2, rn, 10'h305);
      mem[s+10] = enc(0, 0, 0);
      mem[10'h300] = a; mem[10'h301] = b;
      for (int k = 2; k < 6; k++) mem[10'h300 + k] = 16'hDEAD;
      do_reset(s);
      run(cyc);
      r = ref_alu(a, b, sub != 0);
      path = (r == 0) ? 4 : (r[15] ? 5 : 3);
      check("R5 random arithmetic", mem[10'h302], r);
      for (int k = 3; k < 6; k++)
        check((k == path) ? "R7 taken marker" : "R7 untouched marker",
              mem[10'h300 + k], (k == path) ? r : 16'hDEAD);
      ins_last = 0;
      check("R3 random halt cycles", cyc,
            3 + 5 + 3 + 2 + ((path == 4) ? 0 : 2) + 3 + 2 + ins_last);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule